// File: doc/BRIEF.md
# Synchronized Multichannel LED PWM Generator

The block drives a bank of LED channels from one shared period counter. Each channel takes an 8-bit duty value and a 6-bit level code. For each channel it produces a gated on/off enable and a 2-bit current-scale code, which go to an external current source. A prescaler divides the system clock down to the slot rate. There are two fixed PWM rates: a fast rate near 24 kHz and a slow rate near 3.6 kHz. Each period has 256 slots, so a duty of N keeps the output high for N of the 256 slots. Every channel turns on at the first slot of the period.

Three shutdown sources act on all outputs at once: a software run bit, a global off bit and an active-low hardware run pin. Shutdown only gates the outputs. The stored duty, level and rate settings are kept, so brightness comes back unchanged when the block is released. New duty, level and rate inputs take effect only at a period boundary, which keeps every pulse whole. Level codes that are neither off codes nor one of the four scale codes turn the channel off and raise a flag.

Top module: `ledpwm_array`

## Requirements
- R1: With the channel enabled and no shutdown active, a channel with duty D is high for exactly D×DIV clock cycles per period. DIV is the divisor of the selected rate. A duty of 0 never goes high, and a duty of 255 is high for 255 of the 256 slots.
- R2: All enabled channels with nonzero duty rise in the same clock cycle, at the start of each period.
- R3: A period lasts 256×DIV cycles. DIV = max(1, CLK_HZ/(rate×256)), where rate is FAST_HZ when `rate_sel_i`=0 and SLOW_HZ when `rate_sel_i`=1.
- R4: Level codes 0x10, 0x11, 0x12 and 0x13 enable the channel. They give `scale_o` codes 0 (full), 1 (11/12), 2 (9/12) and 3 (7/12), taken from the code's two low bits. Codes 0x00–0x0F turn the channel off and give scale code 0.
- R5: Level codes 0x14–0x3F turn the channel off and give scale code 0. `bad_level_o` is high while any channel holds such a code, and low otherwise.
- R6: `sw_run_i`=0 drives all `pwm_o` low from the next clock. The settings are kept, so after release each channel produces its former duty again.
- R7: `gbl_off_i`=1 drives all `pwm_o` low from the next clock. The settings are kept.
- R8: `hw_run_n_i`=0 drives all `pwm_o` low from the next clock. The settings are kept.
- R9: Duty, level and rate inputs are captured only at the period boundary. A change made in the middle of a period alters neither the pulse width nor `scale_o` until the next period.
- R10: During reset `pwm_o`, `scale_o` and `bad_level_o` are all 0, and the first period after reset runs at the fast rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| duty_i | input | NCH*DUTY_W | Per-channel duty; channel k uses bits [k*DUTY_W +: DUTY_W] |
| level_i | input | NCH*6 | Per-channel level code; channel k uses bits [k*6 +: 6] |
| rate_sel_i | input | 1 | 0 selects the fast rate, 1 the slow rate |
| sw_run_i | input | 1 | Software run bit; 0 darkens all outputs |
| gbl_off_i | input | 1 | Global off; 1 darkens all outputs |
| hw_run_n_i | input | 1 | Hardware run pin, active low; 0 darkens all outputs |
| pwm_o | output | NCH | Per-channel gated on/off enable |
| scale_o | output | NCH*2 | Per-channel current-scale code, channel k at [k*2 +: 2] |
| bad_level_o | output | 1 | High while any channel holds an illegal level code |

## Verification
Two events can fall in the same clock edge: the period boundary that loads the shadow settings, and an input change or shutdown that arrives at that moment. Both also meet the per-channel compare.

The bench changes a duty and a level code partway through a period. It then judges the two periods separately: the width of the pulse in flight must keep the old value, and the next period must carry the new one. It also asserts and releases each shutdown source while channels are running, then checks that the following full period reproduces every stored duty exactly.

An exhaustive sweep of all 64 level codes on one channel, beside an untouched reference channel, checks the level decode together with the common start instant.

// File: rtl/ledpwm_pkg.sv
package ledpwm_pkg;

  localparam int LVL_W = 6;
  // Upper four bits that mark an enabling level code
  localparam logic [3:0] LVL_ON_TAG = 4'b0100;

  typedef enum logic [1:0] {
    SCL_FULL = 2'd0,
    SCL_11   = 2'd1,
    SCL_9    = 2'd2,
    SCL_7    = 2'd3
  } scale_e;

  typedef struct packed {
    logic   on;
    logic   bad;
    scale_e scale;
  } lvl_dec_t;

  function automatic lvl_dec_t decode_level(input logic [LVL_W-1:0] code);
    lvl_dec_t r;
    r.on    = 1'b0;
    r.bad   = 1'b0;
    r.scale = SCL_FULL;
    if (code[5:2] == LVL_ON_TAG) begin
      r.on    = 1'b1;
      r.scale = scale_e'(code[1:0]);
    end else if (code[5:4] != 2'b00) begin
      r.bad = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ledpwm_timebase.sv
module ledpwm_timebase #(
  parameter int DIV_FAST = 32,
  parameter int DIV_SLOW = 217,
  parameter int SLOT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_sel_i,
  output logic              tick_o,
  output logic              wrap_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int PRE_W   = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
  localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(DIV_SLOW - 1);

  logic [PRE_W-1:0]  pre_q, pre_d, pre_last;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              rate_q, rate_d;

  always_comb begin
    pre_last = rate_q ? LAST_SLOW : LAST_FAST;
    tick_o   = (pre_q == pre_last);
    wrap_o   = tick_o && (slot_q == '1);
    pre_d    = tick_o ? '0 : pre_q + 1'b1;
    slot_d   = tick_o ? slot_q + 1'b1 : slot_q;
    // rate switches only where the prescaler restarts from zero
    rate_d   = wrap_o ? rate_sel_i : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slot_q <= '0;
      rate_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      slot_q <= slot_d;
      rate_q <= rate_d;
    end
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/ledpwm_lane.sv
module ledpwm_lane
  import ledpwm_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [DUTY_W-1:0] slot_i,
  output logic              pwm_o,
  output logic [1:0]        scale_o,
  output logic              bad_o,
  output logic [DUTY_W-1:0] duty_q_o
);

  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [LVL_W-1:0]  level_q, level_d;
  logic              pwm_q, pwm_d;
  lvl_dec_t          dec;

  always_comb begin
    duty_d  = load_i ? duty_i  : duty_q;
    level_d = load_i ? level_i : level_q;
    dec     = decode_level(level_q);
    pwm_d   = run_i && dec.on && (slot_i < duty_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      level_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      duty_q  <= duty_d;
      level_q <= level_d;
      pwm_q   <= pwm_d;
    end
  end

  assign pwm_o    = pwm_q;
  assign scale_o  = dec.scale;
  assign bad_o    = dec.bad;
  assign duty_q_o = duty_q;

endmodule

// File: rtl/ledpwm_array.sv
module ledpwm_array
  import ledpwm_pkg::*;
#(
  parameter int NCH     = 12,
  parameter int DUTY_W  = 8,
  parameter int CLK_HZ  = 200_000_000,
  parameter int FAST_HZ = 24_000,
  parameter int SLOW_HZ = 3_600
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*DUTY_W-1:0] duty_i,
  input  logic [NCH*LVL_W-1:0]  level_i,
  input  logic                  rate_sel_i,
  input  logic                  sw_run_i,
  input  logic                  gbl_off_i,
  input  logic                  hw_run_n_i,
  output logic [NCH-1:0]        pwm_o,
  output logic [NCH*2-1:0]      scale_o,
  output logic                  bad_level_o
);

  localparam int SLOTS         = 1 << DUTY_W;
  localparam int DIV_FAST_RAW  = CLK_HZ / (FAST_HZ * SLOTS);
  localparam int DIV_SLOW_RAW  = CLK_HZ / (SLOW_HZ * SLOTS);
  localparam int DIV_FAST      = (DIV_FAST_RAW < 1) ? 1 : DIV_FAST_RAW;
  localparam int DIV_SLOW      = (DIV_SLOW_RAW < 1) ? 1 : DIV_SLOW_RAW;

  logic [1:0]            rst_pipe;
  logic                  rst_core_n;
  logic                  tick, wrap, run;
  logic [DUTY_W-1:0]     slot;
  logic [NCH-1:0]        lane_bad;
  logic [NCH*DUTY_W-1:0] duty_q_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign run = sw_run_i && !gbl_off_i && hw_run_n_i;

  ledpwm_timebase #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW),
    .SLOT_W   (DUTY_W)
  ) u_tb (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rate_sel_i (rate_sel_i),
    .tick_o     (tick),
    .wrap_o     (wrap),
    .slot_o     (slot)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    ledpwm_lane #(.DUTY_W(DUTY_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .load_i   (wrap),
      .run_i    (run),
      .duty_i   (duty_i[k*DUTY_W +: DUTY_W]),
      .level_i  (level_i[k*LVL_W +: LVL_W]),
      .slot_i   (slot),
      .pwm_o    (pwm_o[k]),
      .scale_o  (scale_o[k*2 +: 2]),
      .bad_o    (lane_bad[k]),
      .duty_q_o (duty_q_flat[k*DUTY_W +: DUTY_W])
    );
  end

  assign bad_level_o = |lane_bad;

endmodule

// File: rtl/ledpwm_array_chk.sv
module ledpwm_array_chk #(
  parameter int NCH    = 12,
  parameter int DUTY_W = 8
) (
  input logic                  clk,
  input logic                  rst_core_n,
  input logic                  sw_run_i,
  input logic                  gbl_off_i,
  input logic                  hw_run_n_i,
  input logic [NCH-1:0]        pwm_o,
  input logic [NCH*2-1:0]      scale_o,
  input logic                  tick,
  input logic                  wrap,
  input logic [DUTY_W-1:0]     slot,
  input logic [NCH-1:0]        lane_bad,
  input logic [NCH*DUTY_W-1:0] duty_q_flat
);

  AST_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(!sw_run_i || gbl_off_i || !hw_run_n_i) |-> (pwm_o == '0)); // R6 R7 R8

  AST_SCALE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$past(wrap && rst_core_n) |-> $stable(scale_o)); // R9

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(tick && rst_core_n) |-> (slot == $past(slot) + 1'b1)); // R3

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$past(tick && rst_core_n) |-> $stable(slot)); // R3

  for (genvar k = 0; k < NCH; k++) begin : g_lane_chk
    AST_ZERO_DARK: assert property (@(posedge clk) disable iff (!rst_core_n)
      ($past(duty_q_flat[k*DUTY_W +: DUTY_W]) == '0) |-> !pwm_o[k]); // R1

    AST_BAD_DARK: assert property (@(posedge clk) disable iff (!rst_core_n)
      $past(lane_bad[k]) |-> !pwm_o[k]); // R5
  end

endmodule

bind ledpwm_array ledpwm_array_chk #(.NCH(NCH), .DUTY_W(DUTY_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .sw_run_i    (sw_run_i),
  .gbl_off_i   (gbl_off_i),
  .hw_run_n_i  (hw_run_n_i),
  .pwm_o       (pwm_o),
  .scale_o     (scale_o),
  .tick        (tick),
  .wrap        (wrap),
  .slot        (slot),
  .lane_bad    (lane_bad),
  .duty_q_flat (duty_q_flat)
);

// File: tb/tb_ledpwm_array.sv
module tb_ledpwm_array;

  localparam int NCH    = 12;
  localparam int CLK_HZ = 12_288_000;
  localparam int DF     = CLK_HZ / (24_000 * 256);
  localparam int DS     = CLK_HZ / (3_600 * 256);

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NCH*8-1:0]   duty_flat;
  logic [NCH*6-1:0]   level_flat;
  logic               rate_sel, sw_run, gbl_off, hw_run_n;
  logic [NCH-1:0]     pwm;
  logic [NCH*2-1:0]   scale;
  logic               bad;

  logic [7:0] duty_v  [NCH];
  logic [5:0] level_v [NCH];

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      duty_flat[i*8 +: 8]  = duty_v[i];
      level_flat[i*6 +: 6] = level_v[i];
    end
  end

  ledpwm_array #(.NCH(NCH), .DUTY_W(8), .CLK_HZ(CLK_HZ)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty_i      (duty_flat),
    .level_i     (level_flat),
    .rate_sel_i  (rate_sel),
    .sw_run_i    (sw_run),
    .gbl_off_i   (gbl_off),
    .hw_run_n_i  (hw_run_n),
    .pwm_o       (pwm),
    .scale_o     (scale),
    .bad_level_o (bad)
  );

  function automatic bit lvl_on(input logic [5:0] c);
    return c[5:2] == 4'b0100;
  endfunction

  function automatic int lvl_scale(input logic [5:0] c);
    return lvl_on(c) ? int'(c[1:0]) : 0;
  endfunction

  function automatic bit lvl_bad(input logic [5:0] c);
    return !lvl_on(c) && (c[5:4] != 2'b00);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Returns at the negedge sample where outputs rise out of an all-dark state
  task automatic wait_start();
    bit prevz = 1'b0;
    forever begin
      @(negedge clk);
      if (prevz && pwm != '0) break;
      prevz = (pwm == '0);
    end
  endtask

  // Called at a period start sample; runs to the next start and checks it
  task automatic measure(input int div, input string tag);
    int hi [NCH];
    int len;
    bit prevz;
    bit anybad;
    logic [NCH-1:0] mask;
    for (int i = 0; i < NCH; i++)
      mask[i] = lvl_on(level_v[i]) && (duty_v[i] != 0);
    chk(pwm == mask, "R2 common start", int'(pwm), int'(mask));
    for (int i = 0; i < NCH; i++) hi[i] = int'(pwm[i]);
    len = 1;
    prevz = (pwm == '0);
    forever begin
      @(negedge clk);
      if (prevz && pwm != '0) break;
      len++;
      for (int i = 0; i < NCH; i++) hi[i] += int'(pwm[i]);
      prevz = (pwm == '0);
    end
    chk(len == 256 * div, "R3 period length", len, 256 * div);
    anybad = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      int exp_hi;
      exp_hi = lvl_on(level_v[i]) ? int'(duty_v[i]) * div : 0;
      chk(hi[i] == exp_hi, tag, hi[i], exp_hi);
      chk(int'(scale[i*2 +: 2]) == lvl_scale(level_v[i]), "R4 scale code",
          int'(scale[i*2 +: 2]), lvl_scale(level_v[i]));
      anybad |= lvl_bad(level_v[i]);
    end
    chk(bad == anybad, "R5 illegal flag", int'(bad), int'(anybad));
  endtask

  task automatic dark_window(input string tag);
    int lit = 0;
    repeat (600) begin
      @(negedge clk);
      if (pwm != '0) lit++;
    end
    chk(lit == 0, tag, lit, 0);
  endtask

  task automatic load_pattern(input int p);
    for (int i = 0; i < NCH; i++) begin
      case (p)
        0: begin duty_v[i] = 8'((i * 23 + 7) & 255); level_v[i] = 6'h10; end
        1: begin duty_v[i] = (i % 2 == 0) ? 8'(255 - i * 3) : 8'(i); level_v[i] = 6'h11; end
        2: begin duty_v[i] = 8'(i * i * 2); level_v[i] = 6'(16 + (i % 4)); end
        default: begin
          duty_v[i]  = (i == 5) ? 8'd0 : ((i == 11) ? 8'd255 : 8'd128);
          level_v[i] = (i == 3) ? 6'h05 : 6'h13;
        end
      endcase
    end
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    rate_sel = 1'b0;
    sw_run   = 1'b1;
    gbl_off  = 1'b0;
    hw_run_n = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      duty_v[i]  = 8'd0;
      level_v[i] = 6'h10;
    end
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(pwm == '0, "R10 reset pwm", int'(pwm), 0);
    chk(scale == '0, "R10 reset scale", int'(scale), 0);
    chk(bad == 1'b0, "R10 reset flag", int'(bad), 0);
    rst_n = 1'b1;

    // R1, R2, R4: several duty/level patterns at the fast rate
    for (int p = 0; p < 4; p++) begin
      load_pattern(p);
      wait_start();
      wait_start();
      measure(DF, "R1 high cycles");
    end

    // R3: slow rate
    load_pattern(0);
    rate_sel = 1'b1;
    wait_start();
    wait_start();
    measure(DS, "R3 slow high cycles");
    rate_sel = 1'b0;
    wait_start();
    wait_start();
    measure(DF, "R3 fast again");

    // R4, R5: every level code on channel 1 beside a reference channel
    for (int i = 0; i < NCH; i++) begin
      duty_v[i]  = 8'd0;
      level_v[i] = 6'h10;
    end
    duty_v[0] = 8'd200;
    duty_v[1] = 8'd128;
    for (int c = 0; c < 64; c++) begin
      level_v[1] = 6'(c);
      wait_start();
      wait_start();
      measure(DF, "R5 level sweep");
    end

    // R9: mid-period change waits for the boundary
    level_v[1] = 6'h10;
    level_v[2] = 6'h10;
    duty_v[0]  = 8'd255;
    duty_v[1]  = 8'd40;
    duty_v[2]  = 8'd10;
    wait_start();
    wait_start();
    begin
      int cnt;
      int cyc;
      bit prevz;
      cnt = int'(pwm[1]);
      cyc = 1;
      prevz = (pwm == '0);
      forever begin
        @(negedge clk);
        if (prevz && pwm != '0) break;
        cyc++;
        cnt += int'(pwm[1]);
        prevz = (pwm == '0);
        if (cyc == 100) begin
          duty_v[1]  = 8'd200;
          level_v[2] = 6'h13;
        end
        if (cyc == 150)
          chk(scale[5:4] == 2'd0, "R9 scale held mid-period", int'(scale[5:4]), 0);
      end
      chk(cnt == 40 * DF, "R9 old width kept", cnt, 40 * DF);
    end
    measure(DF, "R9 new width");

    // R6, R7, R8: each shutdown darkens all and keeps settings
    load_pattern(1);
    wait_start();
    wait_start();
    sw_run = 1'b0;
    dark_window("R6 software shutdown");
    sw_run = 1'b1;
    wait_start();
    wait_start();
    measure(DF, "R6 retained duty");

    gbl_off = 1'b1;
    dark_window("R7 global off");
    gbl_off = 1'b0;
    wait_start();
    wait_start();
    measure(DF, "R7 retained duty");

    hw_run_n = 1'b0;
    dark_window("R8 hardware shutdown");
    hw_run_n = 1'b1;
    wait_start();
    wait_start();
    measure(DF, "R8 retained duty");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule